// File: doc/BRIEF.md
# Sector Write Protection Unit

This block keeps an 8-bit non-volatile protection word and uses it to gate write requests aimed at six memory regions: three single flash sectors, one group of upper sectors handled as a unit, an emulated-EEPROM area, and the area that holds test flash, one-time-programmable cells and the protection word itself. Clearing a bit of the word to 0 switches on write protection for its region, and that cannot be undone. The power-up value is all ones, so every region starts unprotected.

A single protection-write command carries a data byte. Each 0 in the byte permanently programs the matching stored bit to 0. Each 1 in the lower five positions opens a volatile unlock for that region instead. The unlock ends on reset, on a later protection write that carries 0 in that position, or on any read of the protection word. An external bypass input, driven by password logic outside this block, lifts protection on the five liftable regions. Once the top region's bit is 0, that region can never be opened and the protection word is frozen.

Memory write requests come in with a region code. Allowed requests are granted combinationally in the same cycle. Refused requests are dropped and flagged one cycle later.

Top module: `sector_wprot`

## Requirements
- R1: From power-up the stored word reads FFh, every bit of `rgn_allow_o` is 1, and `mem_wr_err_o` is 0 after reset.
- R2: Region code and bit position match: 0, 1 and 2 are single sectors, 3 is the upper-sector group, 4 is the emulated-EEPROM area and 5 is the test/OTP/protection area. `rgn_allow_o[i]` is 0 exactly when region i is effectively protected.
- R3: On a protection write, every data bit that is 0 clears the matching stored bit on that clock edge, across all 8 bits. A stored bit never returns to 1, not even through reset.
- R4: On a protection write, data bits 4:0 that are 1 set the volatile unlock of the matching region, and bits that are 0 clear it. An unlocked region is allowed even though its stored bit is 0.
- R5: `cfg_rdata_o` always presents the stored word. A cycle with `cfg_rd_i` high clears every volatile unlock at that clock edge.
- R6: Reset clears every volatile unlock and leaves the stored word unchanged.
- R7: While `bypass_i` is high, regions 0 to 4 are allowed whatever their stored bits are. Region 5 is not affected by the bypass.
- R8: Once stored bit 5 is 0, region 5 is denied even with the bypass high, and every later protection write is ignored completely. Stored bits and unlocks keep their values.
- R9: `mem_wr_grant_o` equals `mem_wr_req_i` ANDed with the allow bit of the addressed region, in the same cycle. A request that is not granted makes `mem_wr_err_o` high for exactly the following cycle.
- R10: Region codes 6 and 7 are never granted, and a request with either code is flagged as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass_i | input | 1 | Password bypass, lifts regions 0 to 4 |
| cfg_wr_i | input | 1 | Protection-write command strobe |
| cfg_wdata_i | input | 8 | Protection-write data byte |
| cfg_rd_i | input | 1 | Read strobe for the protection word |
| cfg_rdata_o | output | 8 | Stored protection word |
| mem_wr_req_i | input | 1 | Memory write request |
| mem_wr_rgn_i | input | 3 | Region code of the request |
| mem_wr_grant_o | output | 1 | Request passed to the memory |
| mem_wr_err_o | output | 1 | Pulse one cycle after a refused request |
| rgn_allow_o | output | 6 | Per-region write-allow |

## Verification
The grant, the allow vector and the read data are all combinational from registered state. Their values for a step are sampled a quarter period after the inputs change and before the next rising edge, so a protection write, read or reset shows its effect only from the following step on. The error flag passes through one register, so each step's expected error value describes the request made in the step before. Each vector row records the outputs as they stand before its own clock edge, and the reset and freeze corner cases are placed as rows in that same timeline.

// File: rtl/wp_pkg.sv
// Package for the sector write protection unit: sizes and region codes.
// Assumes the liftable regions occupy the low bit positions and the
// freezing region sits directly above them.
package wp_pkg;
    localparam int REG_W     = 8;   // stored protection word width
    localparam int N_RGN     = 6;   // regions with a protection bit
    localparam int N_LIFT    = 5;   // regions whose protection can be lifted
    localparam int FRZ_BIT   = 5;   // region whose bit freezes the word
    localparam int RGN_IDX_W = 3;   // width of a region code

    typedef enum logic [RGN_IDX_W-1:0] {
        RGN_SEC0  = 3'd0,
        RGN_SEC1  = 3'd1,
        RGN_SEC2  = 3'd2,
        RGN_UPPER = 3'd3,
        RGN_EEMU  = 3'd4,
        RGN_TEST  = 3'd5
    } rgn_e;
endpackage

// File: rtl/wp_nv_store.sv
// Non-volatile protection word model. Bits only move from 1 to 0, the
// power-up value is all ones, and reset does not touch the word. Assumes
// the write enable is not pre-gated; the freeze is applied here.
module wp_nv_store #(
    parameter int REG_W   = 8,
    parameter int FRZ_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] nv_o,
    output logic             frozen_o
);
    logic [REG_W-1:0] nv_q = '1;

    // Freeze is active once the top region's bit has been programmed.
    assign frozen_o = ~nv_q[FRZ_BIT];
    assign nv_o     = nv_q;

    // Program zeros from the data byte unless the word is frozen.
    always_ff @(posedge clk) begin
        if (wr_en && !frozen_o) begin
            nv_q <= nv_q & wr_data;
        end
    end

    // R3
    nv_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_q & ~$past(nv_q)) == '0);

    // R8
    nv_frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && frozen_o) |=> $stable(nv_q));
endmodule

// File: rtl/wp_unlock_shadow.sv
// Volatile unlock flags for the liftable regions. A write loads the data
// bits (1 opens, 0 closes); a read of the protection word or a reset
// closes all of them. Assumes wr_en is already gated by the freeze.
module wp_unlock_shadow #(
    parameter int N_LIFT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [N_LIFT-1:0] wr_data,
    input  logic              rd_clr,
    output logic [N_LIFT-1:0] sh_o
);
    logic [N_LIFT-1:0] sh_q;

    // Reset and reads close the unlocks; writes load them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (rd_clr) begin
            sh_q <= '0;
        end else if (wr_en) begin
            sh_q <= wr_data;
        end
    end

    assign sh_o = sh_q;

    // R5
    sh_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (sh_q == '0));
endmodule

// File: rtl/wp_access_gate.sv
// Per-region allow decode plus the request gate. Liftable regions are
// allowed by the stored bit, the unlock or the bypass; other regions only
// by the stored bit. Codes outside the region range are always refused.
module wp_access_gate #(
    parameter int N_RGN     = 6,
    parameter int N_LIFT    = 5,
    parameter int RGN_IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_RGN-1:0]     nv_bits,
    input  logic [N_LIFT-1:0]    sh_bits,
    input  logic                 bypass,
    input  logic                 req,
    input  logic [RGN_IDX_W-1:0] rgn,
    output logic [N_RGN-1:0]     allow_o,
    output logic                 grant_o,
    output logic                 err_o
);
    localparam int CODES = 1 << RGN_IDX_W;

    logic [CODES-1:0] allow_pad;
    logic             err_q;

    // Build the allow bit of each region from its own inputs.
    for (genvar i = 0; i < N_RGN; i++) begin : g_rgn
        if (i < N_LIFT) begin : g_lift
            assign allow_o[i] = nv_bits[i] | sh_bits[i] | bypass;
        end else begin : g_fixed
            assign allow_o[i] = nv_bits[i];
        end
    end

    // Unused codes map to zero so they are never granted.
    assign allow_pad = {{(CODES-N_RGN){1'b0}}, allow_o};
    assign grant_o   = req & allow_pad[rgn];

    // Register the refusal flag for a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= req & ~grant_o;
        end
    end

    assign err_o = err_q;

    // R9
    gate_deny_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !grant_o) |=> err_o);

    // R10
    gate_bad_rgn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (int'(rgn) >= N_RGN)) |-> !grant_o);

    // R7
    gate_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && bypass && (int'(rgn) < N_LIFT)) |-> grant_o);
endmodule

// File: rtl/sector_wprot.sv
// Sector write protection unit top. Ties the stored word, the unlock
// flags and the request gate together. Protection writes are dropped
// entirely when the word is frozen. Assumes one command per cycle from
// the configuration side.
module sector_wprot
    import wp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bypass_i,
    input  logic                 cfg_wr_i,
    input  logic [REG_W-1:0]     cfg_wdata_i,
    input  logic                 cfg_rd_i,
    output logic [REG_W-1:0]     cfg_rdata_o,
    input  logic                 mem_wr_req_i,
    input  logic [RGN_IDX_W-1:0] mem_wr_rgn_i,
    output logic                 mem_wr_grant_o,
    output logic                 mem_wr_err_o,
    output logic [N_RGN-1:0]     rgn_allow_o
);
    logic [REG_W-1:0]  nv_word;
    logic [N_LIFT-1:0] sh_bits;
    logic              frozen;
    logic              sh_wr;

    // Unlock flags follow writes only while the word is not frozen.
    assign sh_wr       = cfg_wr_i & ~frozen;
    assign cfg_rdata_o = nv_word;

    wp_nv_store #(
        .REG_W   (REG_W),
        .FRZ_BIT (FRZ_BIT)
    ) u_nv (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_i),
        .wr_data  (cfg_wdata_i),
        .nv_o     (nv_word),
        .frozen_o (frozen)
    );

    wp_unlock_shadow #(
        .N_LIFT (N_LIFT)
    ) u_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sh_wr),
        .wr_data (cfg_wdata_i[N_LIFT-1:0]),
        .rd_clr  (cfg_rd_i),
        .sh_o    (sh_bits)
    );

    wp_access_gate #(
        .N_RGN     (N_RGN),
        .N_LIFT    (N_LIFT),
        .RGN_IDX_W (RGN_IDX_W)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .nv_bits (nv_word[N_RGN-1:0]),
        .sh_bits (sh_bits),
        .bypass  (bypass_i),
        .req     (mem_wr_req_i),
        .rgn     (mem_wr_rgn_i),
        .allow_o (rgn_allow_o),
        .grant_o (mem_wr_grant_o),
        .err_o   (mem_wr_err_o)
    );

    // R8
    top_frz_rgn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req_i && (int'(mem_wr_rgn_i) == FRZ_BIT) && !cfg_rdata_o[FRZ_BIT])
        |-> !mem_wr_grant_o);

    // R6
    top_reset_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> $stable(cfg_rdata_o));
endmodule

// File: tb/sector_wprot_tb.sv
// Vector bench for sector_wprot: a table of steps walked in order, each
// row holding the stimulus and the outputs expected before its clock edge.
module sector_wprot_tb;
    localparam logic [2:0] K_IDLE = 3'd0;
    localparam logic [2:0] K_REQ  = 3'd1;
    localparam logic [2:0] K_PWR  = 3'd2;
    localparam logic [2:0] K_RD   = 3'd3;
    localparam logic [2:0] K_RST  = 3'd4;

    typedef struct packed {
        logic [2:0] kind;
        logic [7:0] data;
        logic       byp;
        logic [2:0] rgn;
        logic [5:0] allow;
        logic       grant;
        logic [7:0] rdata;
        logic       err;
    } step_t;

    localparam int NSTEP = 24;
    localparam step_t STEPS [NSTEP] = '{
        '{K_IDLE, 8'h00, 1'b0, 3'd0, 6'h3F, 1'b0, 8'hFF, 1'b0}, // R1 delivery
        '{K_REQ,  8'h00, 1'b0, 3'd0, 6'h3F, 1'b1, 8'hFF, 1'b0}, // R9 grant
        '{K_PWR,  8'hF8, 1'b0, 3'd0, 6'h3F, 1'b0, 8'hFF, 1'b0}, // R3 program 2:0
        '{K_REQ,  8'h00, 1'b0, 3'd1, 6'h38, 1'b0, 8'hF8, 1'b0}, // R2 sector1 blocked
        '{K_REQ,  8'h00, 1'b0, 3'd3, 6'h38, 1'b1, 8'hF8, 1'b1}, // R9 err pulse
        '{K_PWR,  8'hFF, 1'b0, 3'd0, 6'h38, 1'b0, 8'hF8, 1'b0}, // R4 unlock all
        '{K_REQ,  8'h00, 1'b0, 3'd2, 6'h3F, 1'b1, 8'hF8, 1'b0}, // R4 unlocked
        '{K_RD,   8'h00, 1'b0, 3'd0, 6'h3F, 1'b0, 8'hF8, 1'b0}, // R5 read
        '{K_REQ,  8'h00, 1'b0, 3'd2, 6'h38, 1'b0, 8'hF8, 1'b0}, // R5 relocked
        '{K_IDLE, 8'h00, 1'b1, 3'd0, 6'h3F, 1'b0, 8'hF8, 1'b1}, // R7 bypass
        '{K_REQ,  8'h00, 1'b1, 3'd0, 6'h3F, 1'b1, 8'hF8, 1'b0}, // R7 bypass grant
        '{K_PWR,  8'hEF, 1'b0, 3'd0, 6'h38, 1'b0, 8'hF8, 1'b0}, // R3 R4 eeprom
        '{K_REQ,  8'h00, 1'b0, 3'd4, 6'h2F, 1'b0, 8'hE8, 1'b0}, // R2 eeprom blocked
        '{K_PWR,  8'hFB, 1'b0, 3'd0, 6'h2F, 1'b0, 8'hE8, 1'b1}, // R4 close 2
        '{K_RST,  8'h00, 1'b0, 3'd0, 6'h3B, 1'b0, 8'hE8, 1'b0}, // R6 reset
        '{K_REQ,  8'h00, 1'b0, 3'd2, 6'h28, 1'b0, 8'hE8, 1'b0}, // R6 unlocks gone
        '{K_REQ,  8'h00, 1'b0, 3'd6, 6'h28, 1'b0, 8'hE8, 1'b1}, // R10 bad code
        '{K_PWR,  8'hDF, 1'b0, 3'd0, 6'h28, 1'b0, 8'hE8, 1'b1}, // R8 freeze
        '{K_REQ,  8'h00, 1'b0, 3'd5, 6'h1F, 1'b0, 8'hC8, 1'b0}, // R8 test area
        '{K_PWR,  8'h00, 1'b0, 3'd0, 6'h1F, 1'b0, 8'hC8, 1'b1}, // R8 ignored write
        '{K_REQ,  8'h00, 1'b1, 3'd5, 6'h1F, 1'b0, 8'hC8, 1'b0}, // R7 R8 no bypass
        '{K_RD,   8'h00, 1'b0, 3'd0, 6'h1F, 1'b0, 8'hC8, 1'b1}, // R5 read
        '{K_REQ,  8'h00, 1'b0, 3'd3, 6'h08, 1'b1, 8'hC8, 1'b0}, // R2 upper group
        '{K_IDLE, 8'h00, 1'b0, 3'd7, 6'h08, 1'b0, 8'hC8, 1'b0}  // R10 idle
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bypass_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [7:0] cfg_wdata_i = '0;
    logic       cfg_rd_i = 1'b0;
    logic [7:0] cfg_rdata_o;
    logic       mem_wr_req_i = 1'b0;
    logic [2:0] mem_wr_rgn_i = '0;
    logic       mem_wr_grant_o;
    logic       mem_wr_err_o;
    logic [5:0] rgn_allow_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sector_wprot u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bypass_i       (bypass_i),
        .cfg_wr_i       (cfg_wr_i),
        .cfg_wdata_i    (cfg_wdata_i),
        .cfg_rd_i       (cfg_rd_i),
        .cfg_rdata_o    (cfg_rdata_o),
        .mem_wr_req_i   (mem_wr_req_i),
        .mem_wr_rgn_i   (mem_wr_rgn_i),
        .mem_wr_grant_o (mem_wr_grant_o),
        .mem_wr_err_o   (mem_wr_err_o),
        .rgn_allow_o    (rgn_allow_o)
    );

    task automatic check(input string req, input int step, input logic [7:0] act,
                         input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s step %0d: actual=%h expected=%h", req, step, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NSTEP; s++) begin
            @(negedge clk);
            rst_n        = (STEPS[s].kind != K_RST);
            bypass_i     = STEPS[s].byp;
            cfg_wr_i     = (STEPS[s].kind == K_PWR);
            cfg_wdata_i  = STEPS[s].data;
            cfg_rd_i     = (STEPS[s].kind == K_RD);
            mem_wr_req_i = (STEPS[s].kind == K_REQ);
            mem_wr_rgn_i = STEPS[s].rgn;
            #5;
            check("R2 allow", s, {2'b00, rgn_allow_o}, {2'b00, STEPS[s].allow});
            check("R9 grant", s, {7'd0, mem_wr_grant_o}, {7'd0, STEPS[s].grant});
            check("R3 rdata", s, cfg_rdata_o, STEPS[s].rdata);
            check("R9 err", s, {7'd0, mem_wr_err_o}, {7'd0, STEPS[s].err});
        end
        // R3 R6: a second reset leaves the frozen word and its allow map intact
        @(negedge clk);
        rst_n = 1'b0;
        cfg_wr_i = 1'b0;
        cfg_rd_i = 1'b0;
        mem_wr_req_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check("R6 word kept", NSTEP, cfg_rdata_o, 8'hC8);
        check("R6 allow", NSTEP, {2'b00, rgn_allow_o}, 8'h08);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule